// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Model

This block is a clocked static memory that can be built into logic. It takes one command per clock: a read, a write or a deselect. Reads and writes may follow each other in any order, and no idle cycle is needed when the bus changes direction. A static mode input picks one of two read paths. The flow-through path returns data one edge after the command is captured. The pipelined path adds an output register, so data appears one edge later still. Write data follows its address by a fixed lag: one edge in flow-through mode and two edges in pipelined mode.

Each word has four 9-bit lanes, and each lane has its own write enable. A new access starts with a load cycle. Advance cycles then walk a 4-beat burst that is either linear or interleaved. Three chip enables must all be active before a load is accepted. An output enable and a sleep input gate the outputs at once. Sleep also freezes every internal stage and keeps the stored data. A read that hits a write whose data has not yet been stored returns that write's data, merged lane by lane with the stored word.

Top module: `nbt_sram`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its pipeline and burst state. From then on `dout_vld` is 0 and `dout` is 0 until a read result is due.
- R2: With `pipe_mode`=0, a read captured at edge E drives `dout_vld`=1 and the word on `dout` after edge E+1, for exactly one cycle per read.
- R3: With `pipe_mode`=1, a read captured at edge E drives its word after edge E+2, for exactly one cycle per read.
- R4: The data for a write captured at edge E is taken from `din` at edge E+1 when `pipe_mode`=0, or at edge E+2 when `pipe_mode`=1. `din` at any other edge has no effect.
- R5: `byte_we[i]` controls lane i, which is bits [9i+8:9i]. A write changes only the lanes whose enable is 1 and leaves the other lanes as they were.
- R6: Reads and writes may be issued in any order on consecutive cycles. A read returns the word as left by every write issued before it, including a write whose data arrives at the same edge at which the read is served.
- R7: A load (`adv_ld`=0) is accepted only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Otherwise the cycle is a deselect: no word is written and no read result is produced.
- R8: `oe_n`=1 forces `dout` to 0 and `dout_vld` to 0 at once, without waiting for a clock edge. It does not disturb reads or writes in flight, and results due after it returns to 0 appear as usual.
- R9: An advance (`adv_ld`=1) continues the last load with beat index k = 1, 2, 3, 0, and so on. The address keeps the load's upper bits. The low two bits are start+k mod 4 when `burst_ilv`=0, or start XOR k when `burst_ilv`=1. The command type comes from the load. `byte_we` is taken from the current cycle and `addr` is ignored. An advance after a deselect is also a deselect.
- R10: While `sleep` is 1, `dout` and `dout_vld` are 0 and every clock edge is ignored. Commands, write-data slots and stages in flight hold still, and stored words are kept. Operation resumes where it stopped once `sleep` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through; static outside reset |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| sleep | input | 1 | Suspend operation, outputs forced inactive |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_en | input | 1 | On a load, 1 = write and 0 = read |
| byte_we | input | 4 | Per-lane write enables, lane i = bits [9i+8:9i] |
| addr | input | ADDR_W | Word address, used on loads |
| din | input | 36 | Write data, sampled at the late-write slot |
| dout | output | 36 | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data on `dout` is valid this cycle |

## Verification
The collision that matters most is a read served at the same edge as a pending write to the same word arrives. In pipelined mode this happens when a read directly follows a write to that address. The bench provokes it with partial-lane writes followed at once by reads of the same word, in fixed patterns and in a long random mix over eight addresses. A behavioural model applies each write's data at its slot edge before it serves the read captured one edge earlier, and the output is compared on every cycle. Sleep and output-enable gating are also laid over reads in flight: the outputs must blank and the results must then come back in order.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits of burst beat 'beat' from start offset 'start'
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nbt_cmd.sv
`timescale 1ns/1ps
module nbt_cmd #(
  parameter int ADDR_W  = 6,
  parameter int N_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                adv_ld,
  input  logic                wr_en,
  input  logic                sel,
  input  logic                ilv,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [N_BYTES-1:0]  byte_we,
  output nbt_pkg::op_e        s1_op,
  output logic [ADDR_W-1:0]   s1_addr,
  output logic [N_BYTES-1:0]  s1_be
);
  import nbt_pkg::*;

  op_e               b_op, n_op;
  logic [ADDR_W-1:0] b_base, n_addr;
  logic [1:0]        b_cnt, n_cnt;

  always_comb begin
    if (!adv_ld) begin
      n_op   = sel ? (wr_en ? OP_WR : OP_RD) : OP_IDLE;
      n_cnt  = 2'd0;
      n_addr = addr;
    end else begin
      n_op   = b_op;
      n_cnt  = b_cnt + 2'd1;
      n_addr = {b_base[ADDR_W-1:2], beat_lo(b_base[1:0], n_cnt, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_op    <= OP_IDLE;
      b_cnt   <= 2'd0;
      b_base  <= '0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (!hold) begin
      b_op    <= n_op;
      b_cnt   <= n_cnt;
      if (!adv_ld) b_base <= addr;
      s1_op   <= n_op;
      s1_addr <= n_addr;
      s1_be   <= byte_we;
    end
  end

endmodule

// File: rtl/nbt_late.sv
`timescale 1ns/1ps
module nbt_late #(
  parameter int ADDR_W  = 6,
  parameter int N_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                pipe,
  input  nbt_pkg::op_e        s1_op,
  input  logic [ADDR_W-1:0]   s1_addr,
  input  logic [N_BYTES-1:0]  s1_be,
  output logic                wr_go,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [N_BYTES-1:0]  wr_be,
  output logic                rd_go,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [N_BYTES-1:0]  fwd_be
);
  import nbt_pkg::*;

  op_e                s2_op;
  logic [ADDR_W-1:0]  s2_addr;
  logic [N_BYTES-1:0] s2_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (!hold) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // the write whose data is on din at this edge
  assign wr_go   = !hold && (pipe ? (s2_op == OP_WR) : (s1_op == OP_WR));
  assign wr_addr = pipe ? s2_addr : s1_addr;
  assign wr_be   = pipe ? s2_be : s1_be;

  assign rd_go   = !hold && (s1_op == OP_RD);
  assign rd_addr = s1_addr;

  // an older write landing at the same edge as this read must be merged in
  assign fwd_be  = (pipe && s2_op == OP_WR && s2_addr == s1_addr) ? s2_be : '0;

endmodule

// File: rtl/nbt_array.sv
`timescale 1ns/1ps
module nbt_array #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 4,
  localparam int WORD_W = BYTE_W * N_BYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                wr_go,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [N_BYTES-1:0]  wr_be,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_go,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]   rd_data
);

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rq;

    always_ff @(posedge clk) begin
      if (wr_go && wr_be[g]) mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
      if (rd_go) rq <= mem[rd_addr];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = rq;
  end

endmodule

// File: rtl/nbt_rdpath.sv
`timescale 1ns/1ps
module nbt_rdpath #(
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 4,
  localparam int WORD_W = BYTE_W * N_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                pipe,
  input  logic                rd_go,
  input  logic [WORD_W-1:0]   rd_raw,
  input  logic [N_BYTES-1:0]  fwd_be,
  input  logic [WORD_W-1:0]   din,
  input  logic                oe_n,
  input  logic                sleep,
  output logic [WORD_W-1:0]   dout,
  output logic                dout_vld
);

  logic               rv1, rv2;
  logic [N_BYTES-1:0] fmask;
  logic [WORD_W-1:0]  fdata, merged, q2, data_int;
  logic               vld_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1   <= 1'b0;
      rv2   <= 1'b0;
      fmask <= '0;
    end else if (!hold) begin
      rv1   <= rd_go;
      rv2   <= rv1;
      fmask <= fwd_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      fdata <= din;
      q2    <= merged;
    end
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = fmask[g] ? fdata[g*BYTE_W +: BYTE_W]
                                                 : rd_raw[g*BYTE_W +: BYTE_W];
  end

  assign vld_int  = pipe ? rv2 : rv1;
  assign data_int = pipe ? q2 : merged;
  assign dout_vld = vld_int & ~oe_n & ~sleep;
  assign dout     = dout_vld ? data_int : '0;

endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 4,
  localparam int WORD_W = BYTE_W * N_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pipe_mode,
  input  logic                burst_ilv,
  input  logic                sleep,
  input  logic                oe_n,
  input  logic                ce_a_n,
  input  logic                ce_b,
  input  logic                ce_c_n,
  input  logic                adv_ld,
  input  logic                wr_en,
  input  logic [N_BYTES-1:0]  byte_we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   din,
  output logic [WORD_W-1:0]   dout,
  output logic                dout_vld
);
  import nbt_pkg::*;

  logic               sel;
  op_e                s1_op;
  logic [ADDR_W-1:0]  s1_addr, wr_addr, rd_addr;
  logic [N_BYTES-1:0] s1_be, wr_be, fwd_be;
  logic               wr_go, rd_go;
  logic [WORD_W-1:0]  rd_raw;

  assign sel = ~ce_a_n & ce_b & ~ce_c_n;

  nbt_cmd #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_cmd (
    .clk(clk), .rst(rst), .hold(sleep), .adv_ld(adv_ld), .wr_en(wr_en),
    .sel(sel), .ilv(burst_ilv), .addr(addr), .byte_we(byte_we),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  nbt_late #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_late (
    .clk(clk), .rst(rst), .hold(sleep), .pipe(pipe_mode),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be),
    .rd_go(rd_go), .rd_addr(rd_addr), .fwd_be(fwd_be)
  );

  nbt_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_array (
    .clk(clk), .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(din),
    .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_raw)
  );

  nbt_rdpath #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_rdpath (
    .clk(clk), .rst(rst), .hold(sleep), .pipe(pipe_mode), .rd_go(rd_go),
    .rd_raw(rd_raw), .fwd_be(fwd_be), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_vld(dout_vld)
  );

endmodule

// File: rtl/nbt_sram_chk.sv
`timescale 1ns/1ps
module nbt_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pipe_mode,
  input logic              sleep,
  input logic              oe_n,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              adv_ld,
  input logic              dout_vld,
  input nbt_pkg::op_e      s1_op,
  input logic [ADDR_W-3:0] s1_hi
);
  import nbt_pkg::*;

  logic sel;
  assign sel = ~ce_a_n & ce_b & ~ce_c_n;

  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout_vld);

  p_flow_lat_r2: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && s1_op == OP_RD && !sleep) |=> (dout_vld || oe_n || sleep));

  p_pipe_lat_r3: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && $past(s1_op == OP_RD && !sleep) && !sleep)
      |=> (dout_vld || oe_n || sleep));

  p_desel_r7: assert property (@(posedge clk) disable iff (rst)
    (!adv_ld && !sel && !sleep) |=> (s1_op == OP_IDLE));

  p_adv_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_ld && !sleep && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

  p_adv_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_ld && !sleep && s1_op != OP_IDLE) |=> (s1_hi == $past(s1_hi)));

  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(s1_op) && $stable(s1_hi)));

endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .sleep(sleep), .oe_n(oe_n),
  .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv_ld(adv_ld),
  .dout_vld(dout_vld), .s1_op(s1_op), .s1_hi(s1_addr[ADDR_W-1:2])
);

// File: tb/test_nbt_sram.sv
`timescale 1ns/1ps
module test_nbt_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam logic [2:0] CE_ON = 3'b010;   // {ce_a_n, ce_b, ce_c_n}

  logic clk = 0, rst = 1, pipe_mode = 0, burst_ilv = 0, sleep = 0, oe_n = 0;
  logic ce_a_n = 1, ce_b = 0, ce_c_n = 1, adv_ld = 0, wr_en = 0;
  logic [3:0]    byte_we = 0;
  logic [AW-1:0] addr = 0;
  logic [35:0]   din = 0;
  logic [35:0]   dout;
  logic          dout_vld;

  nbt_sram #(.ADDR_W(AW)) i_nbt_sram (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .sleep(sleep), .oe_n(oe_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .adv_ld(adv_ld), .wr_en(wr_en), .byte_we(byte_we), .addr(addr),
    .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  always #5 clk = ~clk;

  int    vectors = 0, miscmp = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  typedef struct { int due; int a; logic [3:0] be; } wr_t;
  wr_t         wq[$];
  logic [35:0] ref_mem [NW];
  int          n = 0;
  int          m_op = 0;            // 0 idle, 1 read, 2 write
  int          m_base = 0, m_cnt = 0;
  logic        prv_rd = 0, stg_vld = 0, exp_vld = 0;
  int          prv_a = 0;
  logic [35:0] stg_data = 0, exp_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      n = 0; m_op = 0; m_base = 0; m_cnt = 0; wq.delete();
      prv_rd = 0; stg_vld = 0; exp_vld = 0;
    end else if (!sleep) begin
      logic        nv, sel_now;
      logic [35:0] nd;
      int          op, a, lo;
      while (wq.size() > 0 && wq[0].due == n) begin
        wr_t e;
        e = wq.pop_front();
        for (int b = 0; b < 4; b++)
          if (e.be[b]) ref_mem[e.a][b*9 +: 9] = din[b*9 +: 9];
      end
      nv = prv_rd;
      nd = ref_mem[prv_a];
      if (pipe_mode) begin
        exp_vld = stg_vld; exp_data = stg_data; stg_vld = nv; stg_data = nd;
      end else begin
        exp_vld = nv; exp_data = nd;
      end
      sel_now = !ce_a_n && ce_b && !ce_c_n;
      if (!adv_ld) begin
        op = sel_now ? (wr_en ? 2 : 1) : 0;
        m_base = int'(addr); m_cnt = 0; a = int'(addr);
      end else begin
        op = m_op;
        m_cnt = (m_cnt + 1) % 4;
        lo = burst_ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        a = (m_base / 4) * 4 + lo;
      end
      m_op = op;
      if (op == 2) wq.push_back('{due: n + (pipe_mode ? 2 : 1), a: a, be: byte_we});
      prv_rd = (op == 1);
      prv_a  = a;
      n++;
    end
  end

  // ---------------- checking ----------------
  task automatic check_out();
    logic        ev;
    logic [35:0] ed;
    ev = exp_vld && !oe_n && !sleep;
    ed = ev ? exp_data : 36'd0;
    vectors++;
    if (dout_vld !== ev || dout !== ed) begin
      miscmp++;
      $display("FAIL %s t=%0t: dout_vld=%b dout=%h expected dout_vld=%b dout=%h",
               cur_req, $time, dout_vld, dout, ev, ed);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_out();
  endtask

  // ---------------- stimulus ----------------
  logic [35:0] din_at [int];
  int dcyc = 0, lag = 1;

  task automatic drive(input logic adv, input logic wr, input logic [3:0] be,
                       input logic [AW-1:0] a, input logic [2:0] ce,
                       input logic has_wd, input logic [35:0] wd);
    adv_ld = adv; wr_en = wr; byte_we = be; addr = a;
    {ce_a_n, ce_b, ce_c_n} = ce; sleep = 0;
    if (has_wd) din_at[dcyc + lag] = wd;
    din = din_at.exists(dcyc) ? din_at[dcyc] : (36'h5A5A5A5A5 ^ 36'(dcyc * 7919));
    tick();
    dcyc++;
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [35:0] d);
    drive(1'b0, 1'b1, be, AW'(a), CE_ON, 1'b1, d);
  endtask
  task automatic rd(input int a);
    drive(1'b0, 1'b0, 4'hF, AW'(a), CE_ON, 1'b0, 36'd0);
  endtask
  task automatic idle(input int k);
    for (int i = 0; i < k; i++) drive(1'b0, 1'b0, 4'h0, '0, 3'b110, 1'b0, 36'd0);
  endtask
  task automatic adv_r();
    drive(1'b1, 1'b0, 4'h0, AW'(42), CE_ON, 1'b0, 36'd0);
  endtask
  task automatic adv_w(input logic [3:0] be, input logic [35:0] d);
    drive(1'b1, 1'b1, be, AW'(42), CE_ON, 1'b1, d);
  endtask
  task automatic nap(input int k);   // R10: garbage write command while asleep
    sleep = 1; adv_ld = 0; wr_en = 1; byte_we = 4'hF; addr = '0;
    {ce_a_n, ce_b, ce_c_n} = CE_ON; din = 36'hBADBADBAD;
    for (int i = 0; i < k; i++) tick();
    sleep = 0;
  endtask
  task automatic oe_probe();         // R8: asynchronous blanking mid-cycle
    oe_n = 1; #1 check_out();
    oe_n = 0; #1 check_out();
  endtask

  function automatic logic [35:0] word(input int a, input int salt);
    return 36'(a * 1237 + salt * 99991) ^ 36'hF0F0F0F0F;
  endfunction

  task automatic do_reset();
    rst = 1; adv_ld = 0; {ce_a_n, ce_b, ce_c_n} = 3'b110; sleep = 0; oe_n = 0;
    tick(); tick(); tick();
    rst = 0; dcyc = 0; din_at.delete();
  endtask

  task automatic run_mode(input logic pm);
    pipe_mode = pm; lag = pm ? 2 : 1; burst_ilv = 0;
    cur_req = "R1";
    do_reset();
    idle(2);
    cur_req = "R4 R5";
    for (int a = 0; a < NW; a++) wr(a, 4'hF, word(a, pm));
    idle(2);
    cur_req = pm ? "R3" : "R2";
    for (int i = 0; i < 8; i++) rd((i * 9) % NW);
    idle(3);
    cur_req = "R5 R6";
    wr(10, 4'b0101, word(100, 1)); rd(10);
    wr(11, 4'hF, word(101, 2)); rd(11); rd(10);
    wr(10, 4'b1010, word(102, 3)); wr(10, 4'b0001, word(103, 4)); rd(10); rd(11);
    rd(10); wr(12, 4'b1000, word(104, 5)); rd(12); wr(12, 4'b0110, word(105, 6));
    rd(12); rd(12);
    idle(3);
    cur_req = "R7";
    drive(1'b0, 1'b1, 4'hF, AW'(20), 3'b110, 1'b0, 36'd0);
    drive(1'b0, 1'b1, 4'hF, AW'(20), 3'b000, 1'b0, 36'd0);
    drive(1'b0, 1'b1, 4'hF, AW'(20), 3'b011, 1'b0, 36'd0);
    drive(1'b0, 1'b0, 4'hF, AW'(21), 3'b000, 1'b0, 36'd0);
    idle(2); rd(20); rd(21); idle(3);
    cur_req = "R9";
    rd(6); adv_r(); adv_r(); adv_r(); adv_r();        // linear 2,3,0,1,2
    burst_ilv = 1;
    wr(13, 4'hF, word(200, 1)); adv_w(4'hF, word(201, 2));
    adv_w(4'b0011, word(202, 3)); adv_w(4'hF, word(203, 4));
    rd(12); adv_r(); adv_r(); adv_r();                // interleaved from 0
    rd(15); adv_r(); adv_r(); adv_r();                // interleaved from 3
    burst_ilv = 0;
    idle(1); adv_r(); adv_r();                        // advance after deselect
    idle(3);
    cur_req = "R8";
    rd(1); oe_probe(); rd(2); oe_probe(); rd(3); oe_probe();
    oe_n = 1; rd(4); rd(5); rd(6); oe_n = 0;
    rd(7); idle(3);
    cur_req = "R10";
    wr(30, 4'hF, word(300, 1)); nap(3); rd(30); nap(2); rd(31);
    rd(30); nap(1); wr(30, 4'b0100, word(301, 2)); rd(30); nap(2); idle(3);
    cur_req = "R6";
    for (int i = 0; i < 200; i++) begin
      int a;
      a = $urandom_range(7);
      if ($urandom_range(1)) wr(a, 4'($urandom_range(15)), {4'($urandom), 32'($urandom)});
      else rd(a);
    end
    idle(4);
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #2000000;
    miscmp++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule